// File: doc/BRIEF.md
# Auto-Increment Buffer Pointer Port

This block gives a byte-wide bus a path into packet buffer memory through a single 16-bit pointer. Software loads the pointer one byte at a time. It then reads or writes bytes through a four-byte data window. The pointer selects the target page in one of two ways. It can take the page at the head of the receive queue, or the page named in the packet number register. Both page numbers arrive as inputs from the allocation unit.

The pointer also selects how addresses are formed. In auto-increment mode, every data access uses the pointer's byte offset and then moves that offset forward by one. In byte-lane mode, the low two bits of the data register offset are added to the pointer offset, and the pointer does not move. The byte store is a synchronous RAM inside the block. Every read returns its byte in the cycle after the strobe, and that byte is held until the next read.

Top module: `bufptr_port`

## Requirements
- R1: After reset the pointer is zero, so reading offset 6 or offset 7 returns 0x00.
- R2: A write to offset 6 replaces pointer bits [7:0] only. A write to offset 7 replaces pointer bits [15:8] only.
- R3: A read of offset 6 returns pointer bits [7:0]. A read of offset 7 returns pointer bits [15:8] ANDed with 0xF7, so bit 11 always reads as zero.
- R4: Read data appears on `rdata` in the cycle after the `rd_en` strobe. It stays unchanged until the next `rd_en` strobe.
- R5: Offsets 8 to 11 form the data window. Pointer bit 15 set selects page `rx_head_page`. Bit 15 clear selects page `tx_page`.
- R6: With pointer bit 14 clear, a data access reaches byte (pointer[10:0] + offset[1:0]) mod 2048 of the selected page, and the pointer does not change.
- R7: With pointer bit 14 set, a data access reaches byte pointer[10:0] and ignores offset[1:0]. After the access, bits [10:0] increase by one and wrap from 0x7FF to 0x000. Bits [15:11] do not change. Each access gives one increment, whether it is a read or a write.
- R8: If `rd_en` and `wr_en` are both high on a data window offset, the pair counts as one access with one address. The read returns the byte as it was before the write, and the pointer advances at most once.
- R9: Writes to offsets 0 to 5 and 12 to 15 change neither the pointer nor the memory. Reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| offset | input | 4 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| tx_page | input | PAGE_W | Page from the packet number register |
| rx_head_page | input | PAGE_W | Page at the head of the receive queue |

## Verification
Two functions can land in the same cycle: a data window read and a data window write. Each one, on its own, would also step the pointer. The bench raises both strobes together on one window offset, with auto-increment both on and off. It expects the byte as it stood before the write, and it expects exactly one pointer step. It then reads the pointer and reads back the written byte to confirm both effects. The random phase mixes these paired accesses with pointer rewrites, page changes and wrap-around at 0x7FF. A bench model predicts every returned byte.

// File: rtl/bufptr_pkg.sv
package bufptr_pkg;
  localparam int PTR_W      = 16;
  localparam int OFS_W      = 11;
  localparam int SEL_RX_BIT = 15;
  localparam int AUTO_BIT   = 14;

  localparam logic [3:0] OFF_PTR_LO = 4'd6;
  localparam logic [3:0] OFF_PTR_HI = 4'd7;
  localparam logic [7:0] HI_RD_MASK = 8'hF7;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_REG  = 2'd1,
    SRC_MEM  = 2'd2
  } rd_src_e;

  function automatic logic in_window(input logic [3:0] off);
    return off[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/bufptr_reg.sv
module bufptr_reg
  import bufptr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [7:0]       wbyte,
  input  logic             inc_en,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic [OFS_W-1:0] ofs_next;

  assign ofs_next = ptr_q[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = lo_we | hi_we | inc_en;
    if (lo_we) begin
      ptr_d[7:0] = wbyte;
    end else if (hi_we) begin
      ptr_d[PTR_W-1:8] = wbyte;
    end else if (inc_en) begin
      ptr_d[OFS_W-1:0] = ofs_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/bufptr_addr.sv
module bufptr_addr
  import bufptr_pkg::*;
#(
  parameter int PAGE_W = 1,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [1:0]        lane,
  input  logic [PAGE_W-1:0] tx_page,
  input  logic [PAGE_W-1:0] rx_page,
  output logic [ADDR_W-1:0] mem_addr
);
  logic [OFS_W-1:0]  byte_ofs;
  logic [PAGE_W-1:0] page_sel;
  logic [1:0]        lane_eff;

  always_comb begin
    lane_eff = ptr[AUTO_BIT] ? 2'd0 : lane;
    byte_ofs = ptr[OFS_W-1:0] + {{(OFS_W-2){1'b0}}, lane_eff};
    page_sel = ptr[SEL_RX_BIT] ? rx_page : tx_page;
    mem_addr = {page_sel, byte_ofs};
  end
endmodule

// File: rtl/bufptr_ram.sv
module bufptr_ram #(
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= store[addr];
    end
    if (we) begin
      store[addr] <= wdata;
    end
  end
endmodule

// File: rtl/bufptr_port.sv
module bufptr_port
  import bufptr_pkg::*;
#(
  parameter int PAGE_W = 1,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        offset,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [PAGE_W-1:0] tx_page,
  input  logic [PAGE_W-1:0] rx_head_page
);
  logic [PTR_W-1:0]  ptr_q;
  logic [ADDR_W-1:0] mem_addr;
  logic              win_hit;
  logic              data_acc;
  logic              lo_we, hi_we, inc_en;
  logic [7:0]        ram_q;
  rd_src_e           src_d, src_q;
  logic [7:0]        reg_byte_d, reg_byte_q;

  always_comb begin
    win_hit  = in_window(offset);
    data_acc = (rd_en | wr_en) & win_hit;
    lo_we    = wr_en & (offset == OFF_PTR_LO);
    hi_we    = wr_en & (offset == OFF_PTR_HI);
    inc_en   = data_acc & ptr_q[AUTO_BIT];
  end

  bufptr_reg u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_we  (lo_we),
    .hi_we  (hi_we),
    .wbyte  (wdata),
    .inc_en (inc_en),
    .ptr_q  (ptr_q)
  );

  bufptr_addr #(.PAGE_W(PAGE_W)) u_addr (
    .ptr      (ptr_q),
    .lane     (offset[1:0]),
    .tx_page  (tx_page),
    .rx_page  (rx_head_page),
    .mem_addr (mem_addr)
  );

  bufptr_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_en & win_hit),
    .re    (rd_en & win_hit),
    .addr  (mem_addr),
    .wdata (wdata),
    .rdata (ram_q)
  );

  // read source selection, next state
  always_comb begin
    src_d      = SRC_ZERO;
    reg_byte_d = 8'h00;
    if (win_hit) begin
      src_d = SRC_MEM;
    end else if (offset == OFF_PTR_LO) begin
      src_d      = SRC_REG;
      reg_byte_d = ptr_q[7:0];
    end else if (offset == OFF_PTR_HI) begin
      src_d      = SRC_REG;
      reg_byte_d = ptr_q[PTR_W-1:8] & HI_RD_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q      <= SRC_ZERO;
      reg_byte_q <= 8'h00;
    end else if (rd_en) begin
      src_q      <= src_d;
      reg_byte_q <= reg_byte_d;
    end
  end

  assign rdata = (src_q == SRC_MEM) ? ram_q : reg_byte_q;
endmodule

// File: rtl/bufptr_port_chk.sv
module bufptr_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [3:0]  offset,
  input logic [7:0]  rdata,
  input logic [15:0] ptr_q
);
  logic win, acc, other;
  assign win   = offset[3:2] == 2'b10;
  assign acc   = (rd_en | wr_en) & win;
  assign other = !win && offset != 4'd6 && offset != 4'd7;

  p_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ptr_q[14]) |=> ptr_q[10:0] == $past(ptr_q[10:0]) + 11'd1);

  p_upper_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ptr_q[15:11] == $past(ptr_q[15:11]));

  p_no_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ptr_q[14]) |=> $stable(ptr_q));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_hi_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && offset == 4'd7) |=> rdata[3] == 1'b0);

  p_other_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && other) |=> rdata == 8'h00);

  p_other_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && other) |=> $stable(ptr_q));
endmodule

bind bufptr_port bufptr_port_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .offset (offset),
  .rdata  (rdata),
  .ptr_q  (ptr_q)
);

// File: tb/tb_bufptr_port.sv
module tb_bufptr_port;
  localparam int PAGE_W = 1;
  localparam int MDEPTH = 1 << (PAGE_W + 11);
  localparam time CLK_P = 20ns;

  logic        clk, rst_n, wr_en, rd_en;
  logic [3:0]  offset;
  logic [7:0]  wdata, rdata;
  logic [PAGE_W-1:0] tx_page, rx_head_page;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [15:0] m_ptr;
  logic [7:0]  m_mem [MDEPTH];

  bufptr_port #(.PAGE_W(PAGE_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .offset(offset), .wdata(wdata), .rdata(rdata),
    .tx_page(tx_page), .rx_head_page(rx_head_page)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int m_addr(logic [3:0] o, logic [PAGE_W-1:0] tp, logic [PAGE_W-1:0] rp);
    logic [10:0] ofs;
    logic [PAGE_W-1:0] pg;
    ofs = m_ptr[10:0] + (m_ptr[14] ? 11'd0 : {9'd0, o[1:0]});
    pg  = m_ptr[15] ? rp : tp;
    return int'({pg, ofs});
  endfunction

  function automatic logic [7:0] m_step(bit w, bit r, logic [3:0] o, logic [7:0] d,
                                        logic [PAGE_W-1:0] tp, logic [PAGE_W-1:0] rp);
    logic [7:0] rv;
    int a;
    bit win, auto;
    win  = (o[3:2] == 2'b10);
    auto = m_ptr[14];
    a    = m_addr(o, tp, rp);
    rv   = 8'h00;
    if (r) begin
      if (win) rv = m_mem[a];
      else if (o == 4'd6) rv = m_ptr[7:0];
      else if (o == 4'd7) rv = m_ptr[15:8] & 8'hF7;
    end
    if (w) begin
      if (win) m_mem[a] = d;
      else if (o == 4'd6) m_ptr[7:0] = d;
      else if (o == 4'd7) m_ptr[15:8] = d;
    end
    if ((w || r) && win && auto) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
    return rv;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic op(string tag, bit w, bit r, logic [3:0] o, logic [7:0] d,
                    logic [PAGE_W-1:0] tp, logic [PAGE_W-1:0] rp);
    logic [7:0] exp;
    @(negedge clk);
    wr_en = w; rd_en = r; offset = o; wdata = d; tx_page = tp; rx_head_page = rp;
    exp = m_step(w, r, o, d, tp, rp);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (r) chk(tag, rdata, exp);
  endtask

  task automatic set_ptr(logic [15:0] v);
    op("R2", 1, 0, 4'd6, v[7:0], '0, '0);
    op("R2", 1, 0, 4'd7, v[15:8], '0, '0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED1));
    wr_en = 0; rd_en = 0; offset = 0; wdata = 0; tx_page = 0; rx_head_page = 0;
    m_ptr = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    op("R1", 0, 1, 4'd6, 0, 0, 0);
    op("R1", 0, 1, 4'd7, 0, 0, 0);

    // R2 split halves
    op("R2", 1, 0, 4'd6, 8'h5A, 0, 0);
    op("R2", 0, 1, 4'd6, 0, 0, 0);
    op("R2", 0, 1, 4'd7, 0, 0, 0);
    op("R2", 1, 0, 4'd7, 8'h03, 0, 0);
    op("R2", 0, 1, 4'd6, 0, 0, 0);
    op("R2", 0, 1, 4'd7, 0, 0, 0);

    // R3 high byte mask
    op("R3", 1, 0, 4'd7, 8'hFF, 0, 0);
    op("R3", 0, 1, 4'd7, 0, 0, 0);

    // R4 hold across idle cycles
    held = rdata;
    repeat (4) @(negedge clk);
    chk("R4 hold", rdata, held);

    // fill both pages through auto-increment writes (R7)
    for (int pg = 0; pg < (1 << PAGE_W); pg++) begin
      set_ptr(16'h4000);
      for (int i = 0; i < 2048; i++)
        op("R7", 1, 0, 4'd8 + 4'(i % 4), 8'((pg * 37 + i * 5 + 3) & 8'hFF), PAGE_W'(pg), '0);
    end
    op("R7 after fill", 0, 1, 4'd6, 0, 0, 0);

    // R7 wrap, upper bits kept
    set_ptr(16'h5FFF);
    op("R7 wrap", 1, 0, 4'd9, 8'hAA, 1, 0);
    op("R7 wrap lo", 0, 1, 4'd6, 0, 0, 0);
    op("R7 wrap hi", 0, 1, 4'd7, 0, 0, 0);

    // R6 lane addressing with wrap, pointer fixed
    set_ptr(16'h07FF);
    op("R6 lane0", 0, 1, 4'd8, 0, 1, 0);
    op("R6 lane1 wraps", 0, 1, 4'd9, 0, 1, 0);
    op("R6 lane3", 0, 1, 4'd11, 0, 1, 0);
    op("R6 ptr kept", 0, 1, 4'd6, 0, 1, 0);

    // R5 page select
    set_ptr(16'h8123);
    op("R5", 1, 0, 4'd8, 8'h3C, 0, 1);
    set_ptr(16'h0123);
    op("R5 via tx", 0, 1, 4'd8, 0, 1, 0);
    op("R5 other page", 0, 1, 4'd8, 0, 0, 1);

    // R8 simultaneous read and write
    set_ptr(16'h4010);
    op("R8 old byte", 1, 1, 4'd8, 8'h99, 0, 0);
    op("R8 one step", 0, 1, 4'd6, 0, 0, 0);
    set_ptr(16'h0010);
    op("R8 new byte", 0, 1, 4'd8, 0, 0, 0);
    op("R8 no-inc pair", 1, 1, 4'd10, 8'h42, 0, 0);
    op("R8 no-inc ptr", 0, 1, 4'd6, 0, 0, 0);
    op("R8 no-inc byte", 0, 1, 4'd10, 0, 0, 0);

    // R9 inert offsets
    set_ptr(16'h4020);
    for (int o = 0; o < 16; o++)
      if (o < 6 || o > 11) op("R9", 1, 0, 4'(o), 8'hFF, 0, 0);
    op("R9 ptr lo", 0, 1, 4'd6, 0, 0, 0);
    op("R9 ptr hi", 0, 1, 4'd7, 0, 0, 0);
    for (int o = 0; o < 16; o++)
      if (o < 6 || o > 11) op("R9 read zero", 0, 1, 4'(o), 0, 0, 0);
    op("R9 mem kept", 0, 1, 4'd8, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [7:0] d;
      logic [PAGE_W-1:0] tp, rp;
      k  = int'($urandom % 10);
      d  = 8'($urandom);
      tp = PAGE_W'($urandom);
      rp = PAGE_W'($urandom);
      case (k)
        0: op("R2", 1, 0, 4'd6, d, tp, rp);
        1: op("R2", 1, 0, 4'd7, d & 8'hCF, tp, rp);
        2, 3, 4: op(m_ptr[14] ? "R7" : "R6", 1, 0, 4'd8 + 4'($urandom % 4), d, tp, rp);
        5, 6, 7: op(m_ptr[15] ? "R5" : (m_ptr[14] ? "R7" : "R6"), 0, 1,
                    4'd8 + 4'($urandom % 4), d, tp, rp);
        8: op("R3", 0, 1, 4'd6 + 4'($urandom % 2), d, tp, rp);
        default: begin
          if ($urandom % 2) op("R8", 1, 1, 4'd8 + 4'($urandom % 4), d, tp, rp);
          else op("R9", $urandom % 2 == 1, 1, 4'd12 + 4'($urandom % 4), d, tp, rp);
        end
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule